// File: doc/BRIEF.md
# Byte-Buffered 16-bit Register Access

This block is a small peripheral register file that lets an 8-bit processor bus read and write 16-bit timer registers and 10-bit conversion results without tearing a value across two byte accesses. The timer group holds a free-running counter, two compare registers and an input-capture register. The converter group exposes four read-only result registers whose values arrive on a side input from a converter model. Each 16-bit register occupies a byte pair: upper byte at the even address, lower byte at the next odd address.

Coherence comes from a hidden byte latch per group. Software writes the upper byte first, which only fills the latch, and then the lower byte, which commits both halves in one cycle. Reading the upper byte of the counter or the capture register snapshots the lower half into the latch, so the later lower-byte read returns a value that matches. Compare registers are read directly. A conversion result's upper byte is usable on its own as an 8-bit value. A word access at an even address moves all 16 bits at once. Out-of-order byte sequences are not repaired: the block uses whatever the latch holds.

Top module: `wide_reg_bridge`

## Requirements
- R1: Reset clears the counter, both compare registers, the capture register, both byte latches and the registered read data to zero.
- R2: Address map: timer group at 0x00-0x07 as counter (0x00/0x01), compare A (0x02/0x03), compare B (0x04/0x05), capture (0x06/0x07). Converter results 0..3 at 0x10-0x17, two bytes each. The upper byte sits at the even address. A read of any other address returns 0. Read data is registered on the clock edge that samples the read strobe. A byte read returns its byte in bits 7:0 with bits 15:8 zero. A word read returns the upper byte in bits 15:8.
- R3: A byte write to the upper address of the counter or a compare register loads only the timer latch with write data bits 7:0. The register itself is unchanged.
- R4: A byte write to the lower address of the counter or a compare register commits {timer latch, write data bits 7:0} to that register in one cycle.
- R5: A byte read of the upper address of the counter or the capture register returns the upper byte and copies the lower byte into the timer latch. A byte read of their lower address returns the timer latch, not the live lower byte.
- R6: Byte reads of compare registers return the live byte at either address and leave the timer latch unchanged.
- R7: The capture register and the converter results are read-only. Writes to them, byte or word, change neither the register nor any latch.
- R8: A converter result is left-justified. An upper-byte read returns result bits 9:2 and loads the converter latch with {bits 1:0, 000000}. A lower-byte read returns the converter latch.
- R9: A word access at an even address transfers all 16 bits atomically and leaves both latches unchanged. A word access at an odd address is ignored: it writes nothing and returns 0.
- R10: Timer registers share one latch and converter results share a separate one. A lower-byte access without a matching upper-byte access uses whatever the group latch holds.
- R11: The counter increments by one, wrapping, on each clock with the tick input high. A committed write to the counter in the same cycle takes priority over the increment.
- R12: A capture strobe loads the current counter value into the capture register on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte address |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| bus_rdata | output | 16 | Registered read data |
| cnt_tick | input | 1 | Counter increment enable |
| cap_strobe | input | 1 | Capture event |
| conv_data | input | 40 | Four 10-bit conversion results, result i in bits 10*i+9 : 10*i |

## Verification
On every cycle the assertions check the following: the latch load on an upper-byte write, the compare registers and capture register holding without a qualifying event, the counter tick and the priority of a word write over the tick, the capture load, and the converter latch holding outside upper-byte reads. Multi-access stories can only be shown by the bench's scenarios. These include a lower-byte read returning the snapshot rather than the live counter, a stale latch from one register being committed into another, capture and converter writes failing to disturb the latch, and the two groups keeping separate latches.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  localparam int BYTE_W = 8;
  localparam int CONV_W = 10;

  typedef enum logic [1:0] {
    TR_CNT  = 2'd0,
    TR_CMPA = 2'd1,
    TR_CMPB = 2'd2,
    TR_CAP  = 2'd3
  } tmr_reg_e;

  // Upper byte of a left-justified conversion result: bits 9:2.
  function automatic logic [BYTE_W-1:0] conv_upper(input logic [CONV_W-1:0] r);
    return r[CONV_W-1 -: BYTE_W];
  endfunction

  // Lower byte: remaining bits at the top, zeros below.
  function automatic logic [BYTE_W-1:0] conv_lower(input logic [CONV_W-1:0] r);
    return {r[CONV_W-BYTE_W-1:0], {(2*BYTE_W-CONV_W){1'b0}}};
  endfunction
endpackage

// File: rtl/wrb_timer_group.sv
module wrb_timer_group
  import wrb_pkg::*;
#(
  parameter int REG_W = 2 * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_hit,
  input  logic [1:0]       acc_idx,
  input  logic             acc_lo,
  input  logic             acc_word,
  input  logic             acc_rd,
  input  logic             acc_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             tick,
  input  logic             cap_strobe,
  output logic [REG_W-1:0] rd_val
);
  localparam int BW = REG_W / 2;
  localparam int NUM_CMP = 2;

  logic [REG_W-1:0] cnt_q, cap_q;
  logic [REG_W-1:0] cmp_q [NUM_CMP];
  logic [BW-1:0]    temp_q;
  logic [REG_W-1:0] sel_val, commit_val;

  // Named internal events
  logic writable, snap_reg, direct_rd;
  logic ev_hi_wr, ev_commit, ev_snap, ev_cnt_commit;

  assign writable  = (acc_idx != TR_CAP);
  assign snap_reg  = (acc_idx == TR_CNT) || (acc_idx == TR_CAP);
  assign direct_rd = (acc_idx == TR_CMPA) || (acc_idx == TR_CMPB);

  assign ev_hi_wr      = acc_hit && acc_wr && !acc_word && !acc_lo && writable;
  assign ev_commit     = acc_hit && acc_wr && writable && (acc_word || acc_lo);
  assign ev_snap       = acc_hit && acc_rd && !acc_wr && !acc_word && !acc_lo && snap_reg;
  assign ev_cnt_commit = ev_commit && (acc_idx == TR_CNT);

  assign commit_val = acc_word ? wdata : {temp_q, wdata[BW-1:0]};

  always_comb begin
    case (acc_idx)
      TR_CNT:  sel_val = cnt_q;
      TR_CMPA: sel_val = cmp_q[0];
      TR_CMPB: sel_val = cmp_q[1];
      default: sel_val = cap_q;
    endcase
  end

  always_comb begin
    if (acc_word)
      rd_val = sel_val;
    else if (!acc_lo)
      rd_val = {{BW{1'b0}}, sel_val[REG_W-1 -: BW]};
    else if (direct_rd)
      rd_val = {{BW{1'b0}}, sel_val[BW-1:0]};
    else
      rd_val = {{BW{1'b0}}, temp_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q <= '0;
      cnt_q  <= '0;
      cap_q  <= '0;
    end else begin
      if (ev_hi_wr)      temp_q <= wdata[BW-1:0];
      else if (ev_snap)  temp_q <= sel_val[BW-1:0];
      if (ev_cnt_commit) cnt_q <= commit_val;
      else if (tick)     cnt_q <= cnt_q + 1'b1;
      if (cap_strobe)    cap_q <= cnt_q;
    end
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    logic ev_cmp_commit;
    assign ev_cmp_commit = ev_commit && (acc_idx == 2'(g + 1));

    always_ff @(posedge clk) begin
      if (!rst_n)             cmp_q[g] <= '0;
      else if (ev_cmp_commit) cmp_q[g] <= commit_val;
    end

    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_hit && acc_wr) |=> $stable(cmp_q[g])); // R3
  end

  AST_TEMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hi_wr |=> temp_q == $past(wdata[BW-1:0])); // R3
  AST_CNT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(acc_hit && acc_wr)) |=> cnt_q == REG_W'($past(cnt_q) + 1'b1)); // R11
  AST_WORD_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && acc_wr && acc_word && acc_idx == TR_CNT) |=> cnt_q == $past(wdata)); // R11
  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |=> cap_q == $past(cnt_q)); // R12
  AST_CAP_RO: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_strobe |=> $stable(cap_q)); // R7
endmodule

// File: rtl/wrb_conv_group.sv
module wrb_conv_group
  import wrb_pkg::*;
#(
  parameter int NUM_CONV = 4,
  parameter int REG_W    = 2 * BYTE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_hit,
  input  logic [1:0]                 acc_idx,
  input  logic                       acc_lo,
  input  logic                       acc_word,
  input  logic                       acc_rd,
  input  logic                       acc_wr,
  input  logic [NUM_CONV*CONV_W-1:0] conv_data,
  output logic [REG_W-1:0]           rd_val
);
  localparam int BW = REG_W / 2;

  logic [CONV_W-1:0] res [NUM_CONV];
  logic [CONV_W-1:0] sel_res;
  logic [BW-1:0]     temp_q;
  logic              ev_hi_rd;

  for (genvar g = 0; g < NUM_CONV; g++) begin : g_unpack
    assign res[g] = conv_data[g*CONV_W +: CONV_W];
  end

  assign sel_res  = res[acc_idx];
  assign ev_hi_rd = acc_hit && acc_rd && !acc_wr && !acc_word && !acc_lo;

  always_comb begin
    if (acc_word)     rd_val = {conv_upper(sel_res), conv_lower(sel_res)};
    else if (!acc_lo) rd_val = {{BW{1'b0}}, conv_upper(sel_res)};
    else              rd_val = {{BW{1'b0}}, temp_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        temp_q <= '0;
    else if (ev_hi_rd) temp_q <= conv_lower(sel_res);
  end

  AST_CONV_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_hi_rd |=> $stable(temp_q)); // R8
  AST_CONV_TEMP_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hi_rd |=> temp_q[BW-(CONV_W-BW)-1:0] == '0); // R8
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import wrb_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int NUM_CONV  = 4,
  parameter int CONV_BASE = 16,
  parameter int REG_W     = 2 * BYTE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_word,
  input  logic                       bus_rd,
  input  logic                       bus_wr,
  input  logic [REG_W-1:0]           bus_wdata,
  output logic [REG_W-1:0]           bus_rdata,
  input  logic                       cnt_tick,
  input  logic                       cap_strobe,
  input  logic [NUM_CONV*CONV_W-1:0] conv_data
);
  localparam int TMR_SPAN = 8;
  localparam logic [ADDR_W-1:0] TMR_END = ADDR_W'(TMR_SPAN);
  localparam logic [ADDR_W-1:0] CNV_LO  = ADDR_W'(CONV_BASE);
  localparam logic [ADDR_W-1:0] CNV_END = ADDR_W'(CONV_BASE + 2 * NUM_CONV);

  logic             in_tmr, in_cnv, odd_word, tmr_hit, cnv_hit, any_hit;
  logic [1:0]       acc_idx;
  logic             acc_lo;
  logic [REG_W-1:0] tmr_val, cnv_val, rdata_d;

  assign in_tmr   = bus_addr < TMR_END;
  assign in_cnv   = (bus_addr >= CNV_LO) && (bus_addr < CNV_END);
  assign odd_word = bus_word && bus_addr[0];
  assign tmr_hit  = in_tmr && !odd_word;
  assign cnv_hit  = in_cnv && !odd_word;
  assign any_hit  = tmr_hit || cnv_hit;
  assign acc_idx  = bus_addr[2:1];
  assign acc_lo   = bus_addr[0];

  wrb_timer_group #(.REG_W(REG_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .acc_hit(tmr_hit), .acc_idx(acc_idx),
    .acc_lo(acc_lo), .acc_word(bus_word), .acc_rd(bus_rd), .acc_wr(bus_wr),
    .wdata(bus_wdata), .tick(cnt_tick), .cap_strobe(cap_strobe), .rd_val(tmr_val)
  );

  wrb_conv_group #(.NUM_CONV(NUM_CONV), .REG_W(REG_W)) u_cnv (
    .clk(clk), .rst_n(rst_n), .acc_hit(cnv_hit), .acc_idx(acc_idx),
    .acc_lo(acc_lo), .acc_word(bus_word), .acc_rd(bus_rd), .acc_wr(bus_wr),
    .conv_data(conv_data), .rd_val(cnv_val)
  );

  assign rdata_d = tmr_hit ? tmr_val : (cnv_hit ? cnv_val : '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rdata_d;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !any_hit) |=> bus_rdata == '0); // R2
  AST_BYTE_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_word) |=> bus_rdata[REG_W-1 -: BYTE_W] == '0); // R2
endmodule

// File: tb/sim_wide_reg_bridge.sv
`timescale 1ns/1ps
module sim_wide_reg_bridge;
  typedef struct packed {
    logic        wr;
    logic        rd;
    logic        word;
    logic [4:0]  addr;
    logic [15:0] wd;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b1,5'h02,16'h0000,16'h0000,4'd1},  // R1 compare A reset
    '{1'b1,1'b0,1'b0,5'h02,16'h0012,16'h0000,4'd3},  // R3 upper write -> latch
    '{1'b0,1'b1,1'b0,5'h02,16'h0000,16'h0000,4'd3},  // R3 register unchanged
    '{1'b1,1'b0,1'b0,5'h03,16'h0034,16'h0000,4'd4},  // R4 commit
    '{1'b0,1'b1,1'b1,5'h02,16'h0000,16'h1234,4'd4},  // R4
    '{1'b0,1'b1,1'b0,5'h03,16'h0000,16'h0034,4'd6},  // R6 direct low read
    '{1'b1,1'b0,1'b0,5'h04,16'h00AB,16'h0000,4'd3},  // R3
    '{1'b0,1'b1,1'b0,5'h05,16'h0000,16'h0000,4'd6},  // R6 live low, not latch
    '{1'b1,1'b0,1'b0,5'h05,16'h00CD,16'h0000,4'd4},  // R4
    '{1'b0,1'b1,1'b1,5'h04,16'h0000,16'hABCD,4'd4},  // R4
    '{1'b1,1'b0,1'b1,5'h00,16'hBEEF,16'h0000,4'd9},  // R9 word write
    '{1'b0,1'b1,1'b1,5'h00,16'h0000,16'hBEEF,4'd9},  // R9 word read
    '{1'b0,1'b1,1'b0,5'h00,16'h0000,16'h00BE,4'd5},  // R5 snapshot EF
    '{1'b1,1'b0,1'b1,5'h00,16'h1111,16'h0000,4'd9},  // R9 word write keeps latch
    '{1'b0,1'b1,1'b0,5'h01,16'h0000,16'h00EF,4'd5},  // R5 latch, not live 11
    '{1'b1,1'b0,1'b0,5'h02,16'h0056,16'h0000,4'd10}, // R10 latch=56
    '{1'b1,1'b0,1'b0,5'h05,16'h0078,16'h0000,4'd10}, // R10 commit into B
    '{1'b0,1'b1,1'b1,5'h04,16'h0000,16'h5678,4'd10}, // R10
    '{1'b0,1'b1,1'b0,5'h01,16'h0000,16'h0056,4'd10}, // R10 stale low read
    '{1'b1,1'b0,1'b1,5'h06,16'hFFFF,16'h0000,4'd7},  // R7 capture word write
    '{1'b0,1'b1,1'b1,5'h06,16'h0000,16'h0000,4'd7},  // R7
    '{1'b1,1'b0,1'b0,5'h06,16'h0099,16'h0000,4'd7},  // R7 must not load latch
    '{1'b1,1'b0,1'b0,5'h03,16'h0077,16'h0000,4'd7},  // R7
    '{1'b0,1'b1,1'b1,5'h02,16'h0000,16'h5677,4'd7},  // R7 latch still 56
    '{1'b0,1'b1,1'b0,5'h10,16'h0000,16'h00B5,4'd8},  // R8 bits 9:2
    '{1'b0,1'b1,1'b0,5'h11,16'h0000,16'h00C0,4'd8},  // R8 bits 1:0 at top
    '{1'b0,1'b1,1'b1,5'h16,16'h0000,16'h0040,4'd8},  // R8 word read result 3
    '{1'b1,1'b0,1'b1,5'h10,16'hFFFF,16'h0000,4'd7},  // R7 converter write
    '{1'b0,1'b1,1'b1,5'h10,16'h0000,16'hB5C0,4'd7},  // R7
    '{1'b0,1'b1,1'b0,5'h10,16'h0000,16'h00B5,4'd10}, // R10 conv latch C0
    '{1'b0,1'b1,1'b0,5'h00,16'h0000,16'h0011,4'd10}, // R10 timer latch 11
    '{1'b0,1'b1,1'b0,5'h11,16'h0000,16'h00C0,4'd10}, // R10 separate latches
    '{1'b0,1'b1,1'b1,5'h03,16'h0000,16'h0000,4'd9},  // R9 odd word read
    '{1'b1,1'b0,1'b1,5'h03,16'hAAAA,16'h0000,4'd9},  // R9 odd word write
    '{1'b0,1'b1,1'b1,5'h02,16'h0000,16'h5677,4'd9},  // R9 unchanged
    '{1'b0,1'b1,1'b0,5'h09,16'h0000,16'h0000,4'd2},  // R2 unmapped
    '{1'b0,1'b1,1'b0,5'h01,16'h0000,16'h0011,4'd5}   // R5 latch kept
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_word = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cnt_tick = 1'b0, cap_strobe = 1'b0;
  logic [39:0] conv_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // results 3..0: 0x001, 0x3FF, 0x155, 0x2D7
  assign conv_data = {10'h001, 10'h3FF, 10'h155, 10'h2D7};

  always #2 clk = ~clk;

  wide_reg_bridge u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_word(bus_word),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_tick(cnt_tick), .cap_strobe(cap_strobe), .conv_data(conv_data)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic rd, input logic word,
                        input logic [4:0] addr, input logic [15:0] wd);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_word = word; bus_addr = addr; bus_wdata = wd;
    @(posedge clk);
    #1;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_word = 1'b0;
  endtask

  task automatic pulse_cap();
    @(negedge clk);
    cap_strobe = 1'b1;
    @(posedge clk);
    #1;
    cap_strobe = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 rdata after reset", bus_rdata, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      bus_op(VEC[i].wr, VEC[i].rd, VEC[i].word, VEC[i].addr, VEC[i].wd);
      if (VEC[i].rd)
        check($sformatf("R%0d vector %0d", VEC[i].req, i), bus_rdata, VEC[i].exp);
    end

    // R11 counting on tick
    bus_op(1'b1, 1'b0, 1'b1, 5'h00, 16'h0100);
    @(negedge clk); cnt_tick = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk); cnt_tick = 1'b0;
    bus_op(1'b0, 1'b1, 1'b1, 5'h00, 16'h0000);
    check("R11 five ticks", bus_rdata, 16'h0105);

    // R11 word write beats tick
    @(negedge clk); cnt_tick = 1'b1;
    bus_op(1'b1, 1'b0, 1'b1, 5'h00, 16'h2000);
    bus_op(1'b0, 1'b1, 1'b1, 5'h00, 16'h0000);
    check("R11 word write wins", bus_rdata, 16'h2000);

    // R11 byte commit beats tick
    bus_op(1'b1, 1'b0, 1'b0, 5'h00, 16'h0030);
    bus_op(1'b1, 1'b0, 1'b0, 5'h01, 16'h0040);
    bus_op(1'b0, 1'b1, 1'b1, 5'h00, 16'h0000);
    check("R11 byte commit wins", bus_rdata, 16'h3040);
    @(negedge clk); cnt_tick = 1'b0;

    // R12 capture
    bus_op(1'b1, 1'b0, 1'b1, 5'h00, 16'h4242);
    pulse_cap();
    bus_op(1'b0, 1'b1, 1'b1, 5'h06, 16'h0000);
    check("R12 capture loads counter", bus_rdata, 16'h4242);
    bus_op(1'b0, 1'b1, 1'b0, 5'h06, 16'h0000);
    check("R5 capture upper byte", bus_rdata, 16'h0042);
    bus_op(1'b1, 1'b0, 1'b1, 5'h00, 16'h5555);
    pulse_cap();
    bus_op(1'b0, 1'b1, 1'b0, 5'h07, 16'h0000);
    check("R5 capture low from latch", bus_rdata, 16'h0042);
    bus_op(1'b0, 1'b1, 1'b1, 5'h06, 16'h0000);
    check("R12 second capture", bus_rdata, 16'h5555);

    // R1 reset clears everything again
    bus_op(1'b0, 1'b1, 1'b0, 5'h10, 16'h0000);
    do_reset();
    check("R1 rdata cleared", bus_rdata, 16'h0000);
    bus_op(1'b0, 1'b1, 1'b1, 5'h02, 16'h0000);
    check("R1 compare A cleared", bus_rdata, 16'h0000);
    bus_op(1'b0, 1'b1, 1'b1, 5'h06, 16'h0000);
    check("R1 capture cleared", bus_rdata, 16'h0000);
    bus_op(1'b0, 1'b1, 1'b0, 5'h11, 16'h0000);
    check("R1 converter latch cleared", bus_rdata, 16'h0000);
    bus_op(1'b0, 1'b1, 1'b0, 5'h01, 16'h0000);
    check("R1 timer latch cleared", bus_rdata, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule